// File: doc/BRIEF.md
# Relative-Indexed Result Switch

This block is the operand store of one execution group in a machine without an architectural register file and without condition flags. Each finished command claims the next slot of a circular window of recent 64-bit results. A later command names an operand by how far back that result lies: distance 1 is the newest claimed slot, distance 2 the one before it, and so on up to 63. Zero and sign tests are made straight on the value read out, with the sign bit picked by the operand's width.

A slot is claimed (allocated) when a command issues and filled when its result arrives. The slot's ready bit follows that order, so a reader can tell a pending result from a finished one. A write is visible to readers in the same cycle through a bypass, and it sits in the window from the next cycle on. A paragraph-advance strobe marks the boundary between instruction groups. It only records the head position at the boundary and leaves the window alone, so the next group reads the previous group's results at their normal distances and takes no extra cycles to do so.

Top module: `result_switch`

## Requirements
- R1: After reset, `allocTag` and `paraBase` are 0 and every in-range read returns ready 0, data 0, zero 0 and negative 0.
- R2: `allocTag` shows the head slot. Each cycle with `allocEn` high moves the head on by one. The head wraps from 63 to 0, and it holds in cycles without `allocEn`.
- R3: A read at distance N (1..63) returns slot (head − N) mod 64, where head is the value before any allocation in that cycle. Distance 1 is the newest allocated slot. Both read ports work independently.
- R4: A distance of 0 or above 63 raises that port's range-error output, with ready 0 and data 0.
- R5: A slot reads ready 1 with its stored value once it has been written. A slot that was never written, or that was allocated but not yet written, reads ready 0 and data 0.
- R6: Allocating a slot clears its ready state, so a slot reused after the ring wraps reads not ready until it is written again. If the same slot is allocated and written in one cycle, the write wins.
- R7: When `wrEn` targets the slot that a port reads in the same cycle, that port returns `wrData` with ready 1.
- R8: A write takes effect in the cycle it is presented. From the next cycle the value is held in the slot, whatever paragraph boundaries follow. A later write to an older slot overwrites it.
- R9: `paraAdv` loads `paraBase` with the head value of that cycle, and the new value shows from the next cycle. The strobe changes no slot value and no ready state, so results from before the boundary stay readable at their distances.
- R10: A port's zero output is 1 exactly when the port is ready and the value it returns is 0.
- R11: A port's negative output is 1 exactly when the port is ready and the sign bit of the value it returns is set. The width code picks the sign bit: 0 selects bit 7, 1 selects bit 15, 2 selects bit 31 and 3 selects bit 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| allocEn | input | 1 | Claim the head slot and advance the head |
| allocTag | output | 6 | Index of the slot the next allocation claims |
| wrEn | input | 1 | Write a result |
| wrTag | input | 6 | Slot the result is written to |
| wrData | input | 64 | Result value |
| rdDistA | input | 7 | Backward distance, port A |
| rdWidthA | input | 2 | Sign-width code, port A |
| rdDataA | output | 64 | Read value, port A (0 when not ready) |
| rdReadyA | output | 1 | Port A value is valid |
| rdRangeErrA | output | 1 | Port A distance out of range |
| rdZeroA | output | 1 | Port A zero test |
| rdNegA | output | 1 | Port A sign test |
| rdDistB | input | 7 | Backward distance, port B |
| rdWidthB | input | 2 | Sign-width code, port B |
| rdDataB | output | 64 | Read value, port B (0 when not ready) |
| rdReadyB | output | 1 | Port B value is valid |
| rdRangeErrB | output | 1 | Port B distance out of range |
| rdZeroB | output | 1 | Port B zero test |
| rdNegB | output | 1 | Port B sign test |
| paraAdv | input | 1 | Paragraph-boundary strobe |
| paraBase | output | 6 | Head position recorded at the last boundary |

## Verification
The bench goes after the bypass case, where a write and a read hit the same slot in one cycle; a design without the bypass would report not ready or return stale data. It runs the ring past 64 allocations, so a design that does not clear the ready bit when a slot is allocated would return the previous lap's value as ready. Distances 0, 64 and 127 are applied: a design that only masks the distance to six bits would treat 64 as distance 0 and 127 as distance 63 and read real slots. Reads across paragraph strobes check that the boundary keeps earlier results, and each of the four width codes is applied, so a design that picks the wrong sign bit gives wrong negative outputs.

// File: rtl/rsw_pkg.sv
package rsw_pkg;

  localparam int RSW_PORTS = 2;

  typedef enum logic [1:0] {
    SGN_BYTE = 2'd0,
    SGN_HALF = 2'd1,
    SGN_WORD = 2'd2,
    SGN_QUAD = 2'd3
  } signWidth_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 wrCommit;
    logic [RSW_PORTS-1:0] rdBypass;
  } rswStrobe_t;

  // sign bit position for a width code, clamped to the data width
  function automatic int signBitOf(input signWidth_e w, input int dataW);
    int pos;
    case (w)
      SGN_BYTE: pos = 7;
      SGN_HALF: pos = 15;
      SGN_WORD: pos = 31;
      default:  pos = 63;
    endcase
    return (pos > dataW - 1) ? dataW - 1 : pos;
  endfunction

endpackage

// File: rtl/rsw_ctrl.sv
module rsw_ctrl
  import rsw_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int DIST_W = 7
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                allocEn,
  input  logic                                wrEn,
  input  logic [IDX_W-1:0]                    wrTag,
  input  logic [RSW_PORTS-1:0][DIST_W-1:0]    rdDist,
  input  logic                                paraAdv,
  output logic [IDX_W-1:0]                    head,
  output logic [IDX_W-1:0]                    paraBase,
  output logic [RSW_PORTS-1:0][IDX_W-1:0]     rdIdx,
  output logic [RSW_PORTS-1:0]                rdOk,
  output logic [RSW_PORTS-1:0]                rdRange,
  output rswStrobe_t                          strb
);

  localparam int DEPTH    = 1 << IDX_W;
  localparam int MAX_DIST = DEPTH - 1;

  logic [DEPTH-1:0] validQ;
  logic [DEPTH-1:0] validNext;
  logic [RSW_PORTS-1:0] bypassHit;

  // allocation clears, write sets; write wins on the same slot
  always_comb begin
    validNext = validQ;
    if (allocEn) validNext[head] = 1'b0;
    if (wrEn)    validNext[wrTag] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head     <= '0;
      paraBase <= '0;
      validQ   <= '0;
    end else begin
      validQ <= validNext;
      if (allocEn) head <= head + 1'b1;
      if (paraAdv) paraBase <= head;
    end
  end

  for (genvar g = 0; g < RSW_PORTS; g++) begin : gRead
    assign rdIdx[g]     = head - rdDist[g][IDX_W-1:0];
    assign rdRange[g]   = (rdDist[g] == '0) || (rdDist[g] > DIST_W'(MAX_DIST));
    assign bypassHit[g] = wrEn && (wrTag == rdIdx[g]) && !rdRange[g];
    assign rdOk[g]      = !rdRange[g] && (validQ[rdIdx[g]] || bypassHit[g]);
  end

  assign strb.wrCommit = wrEn;
  assign strb.rdBypass = bypassHit;

  // R2: head moves by exactly one per allocation, wrapping
  a_r2_head_step: assert property (@(posedge clk) disable iff (!rstN)
    allocEn |=> head == $past(head) + 1'b1);

  // R2: head holds without allocation
  a_r2_head_hold: assert property (@(posedge clk) disable iff (!rstN)
    !allocEn |=> $stable(head));

  // R5: a written slot is ready next cycle
  a_r5_write_sets: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> validQ[$past(wrTag)]);

  // R6: an allocated slot that is not written at once is pending
  a_r6_alloc_clears: assert property (@(posedge clk) disable iff (!rstN)
    (allocEn && !(wrEn && wrTag == head)) |=> !validQ[$past(head)]);

  // R9: boundary strobe captures the head
  a_r9_para_capture: assert property (@(posedge clk) disable iff (!rstN)
    paraAdv |=> paraBase == $past(head));

endmodule

// File: rtl/rsw_dpath.sv
module rsw_dpath
  import rsw_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 6
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  rswStrobe_t                          strb,
  input  logic [IDX_W-1:0]                    wrTag,
  input  logic [DATA_W-1:0]                   wrData,
  input  logic [RSW_PORTS-1:0][IDX_W-1:0]     rdIdx,
  input  logic [RSW_PORTS-1:0]                rdOk,
  input  logic [RSW_PORTS-1:0][1:0]           rdWidth,
  output logic [RSW_PORTS-1:0][DATA_W-1:0]    rdData,
  output logic [RSW_PORTS-1:0]                rdZero,
  output logic [RSW_PORTS-1:0]                rdNeg
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] slotMem [DEPTH];

  always_ff @(posedge clk) begin
    if (strb.wrCommit) slotMem[wrTag] <= wrData;
  end

  for (genvar g = 0; g < RSW_PORTS; g++) begin : gPort
    logic [DATA_W-1:0] rawVal;
    int signPos;
    always_comb begin
      rawVal    = strb.rdBypass[g] ? wrData : slotMem[rdIdx[g]];
      rdData[g] = rdOk[g] ? rawVal : '0;
      signPos   = signBitOf(signWidth_e'(rdWidth[g]), DATA_W);
      rdZero[g] = rdOk[g] && (rdData[g] == '0);
      rdNeg[g]  = rdOk[g] && rdData[g][signPos];
    end
  end

  // R8: a committed write lands in its slot at the next edge
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCommit |=> slotMem[$past(wrTag)] == $past(wrData));

endmodule

// File: rtl/result_switch.sv
module result_switch
  import rsw_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 6,
  parameter int DIST_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocEn,
  output logic [IDX_W-1:0]  allocTag,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrTag,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DIST_W-1:0] rdDistA,
  input  logic [1:0]        rdWidthA,
  output logic [DATA_W-1:0] rdDataA,
  output logic              rdReadyA,
  output logic              rdRangeErrA,
  output logic              rdZeroA,
  output logic              rdNegA,
  input  logic [DIST_W-1:0] rdDistB,
  input  logic [1:0]        rdWidthB,
  output logic [DATA_W-1:0] rdDataB,
  output logic              rdReadyB,
  output logic              rdRangeErrB,
  output logic              rdZeroB,
  output logic              rdNegB,
  input  logic              paraAdv,
  output logic [IDX_W-1:0]  paraBase
);

  rswStrobe_t                          strb;
  logic [RSW_PORTS-1:0][DIST_W-1:0]    rdDist;
  logic [RSW_PORTS-1:0][1:0]           rdWidth;
  logic [RSW_PORTS-1:0][IDX_W-1:0]     rdIdx;
  logic [RSW_PORTS-1:0]                rdOk;
  logic [RSW_PORTS-1:0]                rdRange;
  logic [RSW_PORTS-1:0][DATA_W-1:0]    rdData;
  logic [RSW_PORTS-1:0]                rdZero;
  logic [RSW_PORTS-1:0]                rdNeg;

  assign rdDist  = {rdDistB, rdDistA};
  assign rdWidth = {rdWidthB, rdWidthA};

  rsw_ctrl #(.IDX_W(IDX_W), .DIST_W(DIST_W)) uCtrl (
    .clk(clk), .rstN(rstN), .allocEn(allocEn), .wrEn(wrEn), .wrTag(wrTag),
    .rdDist(rdDist), .paraAdv(paraAdv), .head(allocTag), .paraBase(paraBase),
    .rdIdx(rdIdx), .rdOk(rdOk), .rdRange(rdRange), .strb(strb)
  );

  rsw_dpath #(.DATA_W(DATA_W), .IDX_W(IDX_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrTag(wrTag), .wrData(wrData),
    .rdIdx(rdIdx), .rdOk(rdOk), .rdWidth(rdWidth),
    .rdData(rdData), .rdZero(rdZero), .rdNeg(rdNeg)
  );

  assign rdDataA     = rdData[0];
  assign rdReadyA    = rdOk[0];
  assign rdRangeErrA = rdRange[0];
  assign rdZeroA     = rdZero[0];
  assign rdNegA      = rdNeg[0];
  assign rdDataB     = rdData[1];
  assign rdReadyB    = rdOk[1];
  assign rdRangeErrB = rdRange[1];
  assign rdZeroB     = rdZero[1];
  assign rdNegB      = rdNeg[1];

endmodule

// File: tb/sim_result_switch.sv
`timescale 1ns/1ps
module sim_result_switch;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        allocEn = 1'b0, wrEn = 1'b0, paraAdv = 1'b0;
  logic [5:0]  wrTag = '0;
  logic [63:0] wrData = '0;
  logic [6:0]  rdDistA = '0, rdDistB = '0;
  logic [1:0]  rdWidthA = '0, rdWidthB = '0;
  logic [5:0]  allocTag, paraBase;
  logic [63:0] rdDataA, rdDataB;
  logic        rdReadyA, rdRangeErrA, rdZeroA, rdNegA;
  logic        rdReadyB, rdRangeErrB, rdZeroB, rdNegB;

  always #2.5 clk = ~clk;

  result_switch u0 (
    .clk(clk), .rstN(rstN), .allocEn(allocEn), .allocTag(allocTag),
    .wrEn(wrEn), .wrTag(wrTag), .wrData(wrData),
    .rdDistA(rdDistA), .rdWidthA(rdWidthA), .rdDataA(rdDataA), .rdReadyA(rdReadyA),
    .rdRangeErrA(rdRangeErrA), .rdZeroA(rdZeroA), .rdNegA(rdNegA),
    .rdDistB(rdDistB), .rdWidthB(rdWidthB), .rdDataB(rdDataB), .rdReadyB(rdReadyB),
    .rdRangeErrB(rdRangeErrB), .rdZeroB(rdZeroB), .rdNegB(rdNegB),
    .paraAdv(paraAdv), .paraBase(paraBase)
  );

  typedef struct packed {
    logic        alloc;
    logic        wr;
    logic [5:0]  wrBack;   // write slot = head - wrBack
    logic [63:0] data;
    logic [6:0]  distA;
    logic [1:0]  wcA;
    logic [6:0]  distB;
    logic [1:0]  wcB;
    logic        para;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VTAB [NVEC] = '{
    '{1'b1, 1'b1, 6'd0, 64'h0000_0000_0000_00F0, 7'd1,   2'd3, 7'd0,  2'd3, 1'b0},
    '{1'b1, 1'b1, 6'd0, 64'hFFFF_FFFF_FFFF_F000, 7'd1,   2'd0, 7'd1,  2'd3, 1'b0},
    '{1'b1, 1'b0, 6'd0, 64'h0,                   7'd1,   2'd2, 7'd2,  2'd1, 1'b0},
    '{1'b0, 1'b1, 6'd1, 64'h0,                   7'd1,   2'd3, 7'd2,  2'd2, 1'b0},
    '{1'b1, 1'b1, 6'd0, 64'h1234_5678_9ABC_DEF0, 7'd1,   2'd3, 7'd3,  2'd0, 1'b1},
    '{1'b0, 1'b0, 6'd0, 64'h0,                   7'd1,   2'd3, 7'd4,  2'd1, 1'b0},
    '{1'b1, 1'b1, 6'd0, 64'h0000_0000_0000_8000, 7'd64,  2'd3, 7'd63, 2'd3, 1'b0},
    '{1'b1, 1'b0, 6'd0, 64'h0,                   7'd1,   2'd1, 7'd5,  2'd0, 1'b0},
    '{1'b0, 1'b1, 6'd1, 64'h7FFF_FFFF_FFFF_FFFF, 7'd1,   2'd3, 7'd127,2'd3, 1'b0},
    '{1'b1, 1'b1, 6'd0, 64'h0,                   7'd2,   2'd2, 7'd3,  2'd3, 1'b1},
    '{1'b0, 1'b0, 6'd0, 64'h0,                   7'd1,   2'd3, 7'd6,  2'd0, 1'b0},
    '{1'b0, 1'b1, 6'd3, 64'h0000_0000_0000_0055, 7'd3,   2'd0, 7'd3,  2'd3, 1'b0}
  };

  // reference state built from the requirements
  logic [63:0] mData [64];
  bit          mValid [64];
  logic [5:0]  mHead = '0;
  logic [5:0]  mPara = '0;
  int nVec = 0, nErr = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nVec++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkPort(input string tag, input string pn, input logic [6:0] d,
                           input logic [1:0] w, input logic wr, input logic [5:0] wt,
                           input logic [63:0] wd, input logic [63:0] aData,
                           input logic aRdy, input logic aRng, input logic aZ, input logic aN);
    logic [5:0] idx;
    logic rng, byp, rdy, z, n;
    logic [63:0] dat;
    int sb;
    idx = mHead - d[5:0];
    rng = (d == 0) || (d > 63);
    byp = wr && (wt == idx);
    rdy = !rng && (mValid[idx] || byp);
    dat = rdy ? (byp ? wd : mData[idx]) : 64'h0;
    sb  = (w == 2'd0) ? 7 : (w == 2'd1) ? 15 : (w == 2'd2) ? 31 : 63;
    z   = rdy && (dat == 64'h0);
    n   = rdy && dat[sb];
    chk(aRng === rng, {tag, "/R4"}, {pn, " range"}, {63'h0, aRng}, {63'h0, rng});
    chk(aRdy === rdy, {tag, "/R5"}, {pn, " ready"}, {63'h0, aRdy}, {63'h0, rdy});
    chk(aData === dat, {tag, "/R3"}, {pn, " data"}, aData, dat);
    chk(aZ === z, {tag, "/R10"}, {pn, " zero"}, {63'h0, aZ}, {63'h0, z});
    chk(aN === n, {tag, "/R11"}, {pn, " neg"}, {63'h0, aN}, {63'h0, n});
  endtask

  task automatic applyVec(input vec_t v, input string tag);
    logic [5:0] wt;
    @(negedge clk);
    wt       = mHead - v.wrBack;
    allocEn  = v.alloc;
    wrEn     = v.wr;
    wrTag    = wt;
    wrData   = v.data;
    rdDistA  = v.distA;
    rdWidthA = v.wcA;
    rdDistB  = v.distB;
    rdWidthB = v.wcB;
    paraAdv  = v.para;
    #1;
    chk(allocTag === mHead, {tag, "/R2"}, "allocTag", {58'h0, allocTag}, {58'h0, mHead});
    chk(paraBase === mPara, {tag, "/R9"}, "paraBase", {58'h0, paraBase}, {58'h0, mPara});
    checkPort(tag, "A", v.distA, v.wcA, v.wr, wt, v.data, rdDataA, rdReadyA, rdRangeErrA, rdZeroA, rdNegA);
    checkPort(tag, "B", v.distB, v.wcB, v.wr, wt, v.data, rdDataB, rdReadyB, rdRangeErrB, rdZeroB, rdNegB);
    @(posedge clk);
    if (v.alloc) mValid[mHead] = 0;
    if (v.wr) begin mValid[wt] = 1; mData[wt] = v.data; end
    if (v.para) mPara = mHead;
    if (v.alloc) mHead = mHead + 1'b1;
  endtask

  function automatic vec_t mk(input logic a, input logic w, input logic [5:0] wb,
                              input logic [63:0] d, input logic [6:0] da, input logic [1:0] wa,
                              input logic [6:0] db, input logic [1:0] wcb, input logic p);
    vec_t v;
    v = '{a, w, wb, d, da, wa, db, wcb, p};
    return v;
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) begin mValid[i] = 0; mData[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: state right after reset
    applyVec(mk(0, 0, 0, 0, 7'd1, 2'd3, 7'd63, 2'd0, 0), "R1");
    // table walk: R3 R5 R7 R8 R9 R10 R11
    for (int k = 0; k < NVEC; k++) applyVec(VTAB[k], $sformatf("vec%0d", k));
    // R8: value written earlier still held after two paragraph strobes
    applyVec(mk(0, 0, 0, 0, 7'd3, 2'd0, 7'd6, 2'd3, 0), "R8");
    // R2/R6: fill the ring past one full lap
    for (int k = 0; k < 70; k++)
      applyVec(mk(1, 1, 0, 64'hA000 + 64'(k), 7'd1, 2'd1, 7'd63, 2'd3, 0), "R2");
    // R6: claim a slot without writing, then read it back as pending
    applyVec(mk(1, 0, 0, 0, 7'd1, 2'd3, 7'd64, 2'd3, 0), "R6");
    applyVec(mk(0, 0, 0, 0, 7'd1, 2'd3, 7'd2, 2'd3, 0), "R6");
    // R7: fill the pending slot while reading it
    applyVec(mk(0, 1, 1, 64'h8000_0000_0000_0000, 7'd1, 2'd3, 7'd1, 2'd2, 0), "R7");
    // R9: boundary strobe, then results before it remain readable
    applyVec(mk(0, 0, 0, 0, 7'd1, 2'd3, 7'd40, 2'd0, 1), "R9");
    applyVec(mk(1, 1, 0, 64'h0000_0000_8000_0000, 7'd1, 2'd3, 7'd40, 2'd0, 0), "R9");
    applyVec(mk(0, 0, 0, 0, 7'd1, 2'd2, 7'd2, 2'd3, 0), "R9");
    // R4: extreme distances
    applyVec(mk(0, 0, 0, 0, 7'd0, 2'd3, 7'd127, 2'd3, 0), "R4");
    applyVec(mk(0, 0, 0, 0, 7'd63, 2'd3, 7'd64, 2'd3, 0), "R4");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nErr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
      $finish;
    end
  end

endmodule